// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write an external byte-wide static RAM that has no clock of its own. A client presents an address, a direction flag and, for writes, a data byte, and raises a valid line while the controller shows ready. The controller then runs the memory's active-low chip select, output enable and write enable lines and its address bus in a fixed pattern of clock cycles. It also drives the shared data bus during writes and samples it during reads. A read returns its byte on `rd_data`, and each finished access raises `done` for one clock.

Every interval the memory needs is a clock count worked out at elaboration from nanosecond parameters and the clock period. The three intervals are the read strobe length, the write-enable pulse width and the bus-release time after a read. Each count is the ceiling of the interval divided by the period, and never less than one. Output enable stays high through every write, so the memory cannot drive the bus while the controller does. The shorter write-enable pulse, the one allowed when output enable is high, is therefore enough. Between accesses all three strobes rest high, which keeps the memory in standby.

Top module: `sram_ctl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are all 1 and the controller does not drive `mem_dq`.
- R2: A read accepted at a clock edge holds `mem_cs_n`=0, `mem_oe_n`=0, `mem_we_n`=1 and the request address on `mem_addr` for exactly ceil(T_RC_NS/CLK_NS) cycles that follow.
- R3: The byte on `mem_dq` at the edge that ends the read strobe is loaded into `rd_data`, `done` is 1 for exactly the next cycle, and `rd_data` keeps that value until the next read completes (0 after reset).
- R4: After a read strobe, all three strobes are 1 and `req_ready` is 0 for ceil(T_TURN_NS/CLK_NS) cycles before the next request can be taken.
- R5: A write accepted at a clock edge first spends one cycle with `mem_cs_n`=0, `mem_we_n`=1 and `mem_oe_n`=1, with the address and write byte already on the buses.
- R6: The write-enable pulse (`mem_we_n`=0) lasts exactly ceil(T_PWE_NS/CLK_NS) cycles, with `mem_cs_n`=0 and `mem_oe_n`=1 throughout.
- R7: `mem_we_n` returns to 1 one cycle before the address, data and chip select are released. In the cycle after that one, `done` is 1 and `req_ready` is 1.
- R8: The controller drives `mem_dq` only in write cycles (chip select low, output enable high), and what it drives is the accepted write byte.
- R9: A valid request presented while `req_ready` is 0 is ignored: it changes neither the bus activity nor the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Byte address of the request |
| req_wdata | input | DATA_W (8) | Byte to write |
| req_ready | output | 1 | Controller can take a request this cycle |
| done | output | 1 | One-cycle pulse when an access has finished |
| rd_data | output | DATA_W (8) | Byte returned by the latest read |
| mem_addr | output | ADDR_W (19) | Memory address bus |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_dq | inout | DATA_W (8) | Shared bidirectional data bus |

## Verification
The bound checker watches the strobe combinations on every cycle. It checks that the strobes rest while ready is high and that output enable and write enable are never both low. It checks that the data driver is on only with chip select low and output enable high, that address and drive stay steady at the rising edge of write enable, and that the bus-release gap follows a rise of output enable. The exact lengths of the read strobe, the write pulse and the release gap, the byte a read returns, and the fact that a request offered while busy leaves memory untouched can only be shown by the bench. Its cycle-by-cycle reference model and the behavioural memory connected to the bus expose these.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_WAIT  = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } ctl_state_e;

    // Whole clock cycles covering an interval in ns, at least one.
    function automatic int cyc_of(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sram_ctl_cnt.sv
`timescale 1ns/1ps
module sram_ctl_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_io.sv
`timescale 1ns/1ps
module sram_ctl_io #(
    parameter int DW = 8
) (
    input  logic          drv_en,
    input  logic [DW-1:0] dout,
    output logic [DW-1:0] din,
    inout  wire  [DW-1:0] pad
);

    assign pad = drv_en ? dout : {DW{1'bz}};
    assign din = pad;

endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 8,
    parameter int T_RC_NS   = 12,
    parameter int T_PWE_NS  = 8,
    parameter int T_TURN_NS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    inout  wire  [DATA_W-1:0] mem_dq
);

    localparam int RD_CYC = cyc_of(T_RC_NS, CLK_NS);
    localparam int PW_CYC = cyc_of(T_PWE_NS, CLK_NS);
    localparam int TA_CYC = cyc_of(T_TURN_NS, CLK_NS);
    localparam int MAX_CYC = max3(RD_CYC, PW_CYC, TA_CYC);
    localparam int CNT_W = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        ctl_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic [DATA_W-1:0] rdat;
        logic              cs_n;
        logic              oe_n;
        logic              we_n;
        logic              drv;
        logic              done;
    } ctl_regs_t;

    localparam ctl_regs_t RST_VAL = '{
        st:   ST_IDLE,
        addr: '0,
        wdat: '0,
        rdat: '0,
        cs_n: 1'b1,
        oe_n: 1'b1,
        we_n: 1'b1,
        drv:  1'b0,
        done: 1'b0
    };

    ctl_regs_t        r_d, r_q;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_val;
    logic             cnt_zero;
    logic [DATA_W-1:0] bus_in;
    logic             drv_en;

    sram_ctl_cnt #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .zero     (cnt_zero)
    );

    sram_ctl_io #(.DW(DATA_W)) u_io (
        .drv_en (drv_en),
        .dout   (r_q.wdat),
        .din    (bus_in),
        .pad    (mem_dq)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        cnt_load = 1'b0;
        cnt_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                r_d.cs_n = 1'b1;
                r_d.oe_n = 1'b1;
                r_d.we_n = 1'b1;
                r_d.drv  = 1'b0;
                if (req_valid) begin
                    r_d.addr = req_addr;
                    r_d.cs_n = 1'b0;
                    if (req_write) begin
                        r_d.st   = ST_WR_SETUP;
                        r_d.wdat = req_wdata;
                        r_d.drv  = 1'b1;
                    end else begin
                        r_d.st   = ST_RD_WAIT;
                        r_d.oe_n = 1'b0;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD_WAIT: begin
                if (cnt_zero) begin
                    r_d.rdat = bus_in;
                    r_d.done = 1'b1;
                    r_d.cs_n = 1'b1;
                    r_d.oe_n = 1'b1;
                    r_d.st   = ST_RD_TURN;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(TA_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (cnt_zero) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                r_d.we_n = 1'b0;
                r_d.st   = ST_WR_PULSE;
                cnt_load = 1'b1;
                cnt_val  = CNT_W'(PW_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (cnt_zero) begin
                    r_d.we_n = 1'b1;
                    r_d.st   = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: begin
                r_d.cs_n = 1'b1;
                r_d.drv  = 1'b0;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: begin
                r_d = RST_VAL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign drv_en    = r_q.drv;
    assign req_ready = (r_q.st == ST_IDLE);
    assign done      = r_q.done;
    assign rd_data   = r_q.rdat;
    assign mem_addr  = r_q.addr;
    assign mem_cs_n  = r_q.cs_n;
    assign mem_oe_n  = r_q.oe_n;
    assign mem_we_n  = r_q.we_n;

endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              drv_en
);

    // R1
    idle_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_oe_n && mem_we_n && !drv_en));

    // R2
    read_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && !drv_en));

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    turn_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (!req_ready && mem_cs_n && !drv_en));

    // R6
    write_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_cs_n && drv_en));

    // R7
    write_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_cs_n && drv_en && $stable(mem_addr)));

    // R8
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (!mem_cs_n && mem_oe_n));

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .drv_en    (drv_en)
);

// File: tb/sim_sram_ctl.sv
`timescale 1ns/1ps
module sim_sram_ctl;

    localparam int CLK_NS = 8;
    localparam int RC_NS  = 20;
    localparam int PWE_NS = 12;
    localparam int TRN_NS = 10;
    localparam int RD_N = (RC_NS + CLK_NS - 1) / CLK_NS;
    localparam int PW_N = (PWE_NS + CLK_NS - 1) / CLK_NS;
    localparam int TA_N = (TRN_NS + CLK_NS - 1) / CLK_NS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, done;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_oe_n, mem_we_n;
    wire  [7:0]  mem_dq;

    always #4 clk = ~clk;

    sram_ctl #(
        .ADDR_W(19), .DATA_W(8), .CLK_NS(CLK_NS),
        .T_RC_NS(RC_NS), .T_PWE_NS(PWE_NS), .T_TURN_NS(TRN_NS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq)
    );

    // Behavioural memory: write at the end of the select/write overlap.
    logic [7:0] store [0:1023];
    initial begin
        for (int i = 0; i < 1024; i++) store[i] = 8'h00;
    end
    always @(posedge mem_we_n) begin
        if (!mem_cs_n) store[mem_addr[9:0]] = mem_dq;
    end
    assign mem_dq = (!mem_cs_n && !mem_oe_n && mem_we_n) ? store[mem_addr[9:0]] : 8'hzz;

    // Reference model: one expected entry per cycle.
    typedef struct packed {
        logic        cs_n, oe_n, we_n, ready, done, drv, set_rd;
        logic [18:0] addr;
        logic [7:0]  dat;
    } exp_t;

    localparam exp_t REST = '{cs_n:1'b1, oe_n:1'b1, we_n:1'b1, ready:1'b1,
                              done:1'b0, drv:1'b0, set_rd:1'b0, addr:'0, dat:'0};

    exp_t        exp_q [$];
    string       tag_q [$];
    logic [7:0]  ref_mem [int];
    logic [7:0]  model_rd = 8'h00;
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected under 20000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input int got, input int expv);
        n_chk++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
        end
    endtask

    task automatic compare(input exp_t e, input string tag);
        chk(tag, "mem_cs_n", int'(mem_cs_n), int'(e.cs_n));
        chk(tag, "mem_oe_n", int'(mem_oe_n), int'(e.oe_n));
        chk(tag, "mem_we_n", int'(mem_we_n), int'(e.we_n));
        chk(tag, "req_ready", int'(req_ready), int'(e.ready));
        chk(tag, "done", int'(done), int'(e.done));
        if (e.set_rd) model_rd = e.dat;
        chk("R3", "rd_data", int'(rd_data), int'(model_rd));
        if (!e.cs_n) chk(tag, "mem_addr", int'(mem_addr), int'(e.addr));
        if (e.drv) chk("R8", "mem_dq", int'(mem_dq), int'(e.dat));
    endtask

    task automatic push(input exp_t e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic push_access(input logic w, input logic [18:0] a, input logic [7:0] d);
        exp_t e;
        if (w) begin
            ref_mem[int'(a)] = d;
            e = '{cs_n:1'b0, oe_n:1'b1, we_n:1'b1, ready:1'b0, done:1'b0,
                  drv:1'b1, set_rd:1'b0, addr:a, dat:d};
            push(e, "R5");
            for (int i = 0; i < PW_N; i++) begin
                e.we_n = 1'b0;
                push(e, "R6");
            end
            e.we_n = 1'b1;
            push(e, "R7");
            push('{cs_n:1'b1, oe_n:1'b1, we_n:1'b1, ready:1'b1, done:1'b1,
                   drv:1'b0, set_rd:1'b0, addr:'0, dat:'0}, "R7");
        end else begin
            e = '{cs_n:1'b0, oe_n:1'b0, we_n:1'b1, ready:1'b0, done:1'b0,
                  drv:1'b0, set_rd:1'b0, addr:a, dat:'0};
            for (int i = 0; i < RD_N; i++) push(e, "R2");
            for (int i = 0; i < TA_N; i++) begin
                e = '{cs_n:1'b1, oe_n:1'b1, we_n:1'b1, ready:1'b0, done:1'b0,
                      drv:1'b0, set_rd:1'b0, addr:'0, dat:'0};
                if (i == 0) begin
                    e.done   = 1'b1;
                    e.set_rd = 1'b1;
                    e.dat    = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00;
                    push(e, "R3");
                end else begin
                    push(e, "R4");
                end
            end
        end
    endtask

    task automatic cycle(input logic v, input logic w, input logic [18:0] a,
                         input logic [7:0] d, output logic acc);
        exp_t  e;
        string t;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e = REST;
            t = "R1";
        end
        compare(e, t);
        req_valid = v;
        req_write = w;
        req_addr  = a;
        req_wdata = d;
        acc = v && e.ready;
        if (acc) push_access(w, a, d);
    endtask

    task automatic op(input logic w, input logic [18:0] a, input logic [7:0] d);
        logic acc;
        acc = 1'b0;
        while (!acc) cycle(1'b1, w, a, d, acc);
    endtask

    task automatic drain();
        logic acc;
        while (exp_q.size() > 0) cycle(1'b0, 1'b0, '0, '0, acc);
        cycle(1'b0, 1'b0, '0, '0, acc);
    endtask

    initial begin
        logic acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: standby after reset
        repeat (3) cycle(1'b0, 1'b0, '0, '0, acc);

        // single write then read back
        op(1'b1, 19'h00012, 8'hA5);
        drain();
        op(1'b0, 19'h00012, 8'h00);
        drain();

        // top address bits
        op(1'b1, 19'h7FFFF, 8'h3C);
        op(1'b0, 19'h7FFFF, 8'h00);
        drain();

        // back-to-back mix without idle gaps, incl. read followed by write
        op(1'b1, 19'h00100, 8'h5A);
        op(1'b1, 19'h2A155, 8'hC3);
        op(1'b0, 19'h00100, 8'h00);
        op(1'b0, 19'h2A155, 8'h00);
        op(1'b1, 19'h15055, 8'h81);
        op(1'b0, 19'h15055, 8'h00);
        drain();

        // R9: request offered while busy is ignored
        op(1'b0, 19'h00012, 8'h00);
        cycle(1'b1, 1'b1, 19'h00012, 8'hEE, acc);
        cycle(1'b1, 1'b1, 19'h00012, 8'hEE, acc);
        drain();
        op(1'b0, 19'h00012, 8'h00);
        drain();
        chk("R9", "rd_data after busy request", int'(rd_data), 32'hA5);

        // never written location reads zero
        op(1'b0, 19'h40222, 8'h00);
        drain();
        chk("R3", "rd_data unwritten", int'(rd_data), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule